// File: doc/BRIEF.md
# Successive-Approximation ADC Controller

This block is the digital side of an 8-bit successive-approximation converter, managed by a CPU through one control register and one read-only result register. The control register holds a channel code, a done flag that also serves as the software start bit, a switch that keeps the reference tied on, an enable for the external trigger pin, and a choice of interrupt source.

A conversion starts in one of two ways. Software can write 0 into the done flag, or, when the trigger enable is set, a falling edge on the trigger pin starts it. The controller latches the channel and drives it to the analog multiplexer. It then steps a trial code onto the resistor ladder from the most significant bit down. It samples the comparator after a fixed settling time, and on completion it writes the code into the result register.

The ladder, the multiplexer and the comparator are outside this block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset the control register reads 0x10 (done flag set, every other field 0), the result register reads 0x00, and ch_sel, tap_code, ref_on and irq are all 0.
- R2: Control bits 3..0 hold the channel code. Codes 0..12 drive ch_sel with that value, and codes 13..15 drive channel 12. The channel is latched when a conversion starts, so a write to bits 3..0 during a conversion leaves ch_sel and the result unchanged.
- R3: When idle (bit 4 = 1) with bit 6 = 0, a write with bit 4 = 0 starts a conversion. Bit 4 reads 0 from the next cycle until the conversion ends, and then reads 1.
- R4: A write with bit 4 = 1, or any write made while a conversion runs, neither starts a conversion nor changes bit 4. The other fields still take the written values.
- R5: When bit 6 is already 1 before the write, a write with bit 4 = 0 neither starts a conversion nor clears bit 4.
- R6: With bit 6 = 1, a falling edge on trig_n, seen through a two-flop synchronizer, starts a conversion on the stored channel. A falling edge that arrives while a conversion runs is ignored.
- R7: A conversion runs 8 steps from MSB to LSB. Each step presents the trial code on tap_code for SETTLE_CYC cycles and then keeps the trial bit when cmp_in = 1 (input at or above the tap) or clears it otherwise. The first tap of every conversion is 0x80, and the final code equals the input level.
- R8: The result register cannot be written. During a conversion it keeps the previous result, and it takes the new code when the conversion completes.
- R9: With bit 5 = 1, ref_on is high at all times. With bit 5 = 0, ref_on is high only while a conversion runs, one cycle behind it, and low again two cycles after completion.
- R10: With bit 7 = 0, irq is a single-cycle pulse at the completion of each conversion.
- R11: With bit 7 = 1 and bit 6 = 1, irq is a single-cycle pulse for each synchronized falling edge of trig_n, and completion raises no request. With bit 6 = 0, edges on trig_n raise no request and start nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | CPU write strobe for the control register |
| reg_wdata | input | 8 | CPU write data |
| ctrl_q | output | 8 | Control register readback {src, trig_en, ref_sw, done, chan[3:0]} |
| result_q | output | 8 | Conversion result register |
| trig_n | input | 1 | Asynchronous external trigger, active on falling edge |
| cmp_in | input | 1 | Comparator output, 1 when the input is at or above the tap voltage |
| ch_sel | output | 4 | Channel select to the analog multiplexer |
| tap_code | output | 8 | Ladder tap code under trial |
| ref_on | output | 1 | Reference connect enable |
| irq | output | 1 | Single-cycle interrupt request |

## Verification
The bench sets SETTLE_CYC to 2 and keeps the default 8-bit data width, 13 channels and two-stage synchronizer. A conversion then takes about twenty cycles. This short length makes mid-conversion writes, a second trigger edge during a conversion, and the ref_on release after completion all reachable within a few cycles of the stimulus. A behavioural comparator built from a per-channel input level lets the bench check the all-zero and all-ones codes and the clamped channel codes against an expected result it derives directly.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  localparam int FLD_CH_LSB = 0;
  localparam int FLD_DONE   = 4;
  localparam int FLD_REFSW  = 5;
  localparam int FLD_TRIGEN = 6;
  localparam int FLD_IRQSRC = 7;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_STEP = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_adc_trig_sync.sv
module sar_adc_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~chain_q[STAGES-1];

  // R6
  fall_single_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/sar_adc_engine.sv
module sar_adc_engine #(
  parameter int DATA_W     = 8,
  parameter int CH_W       = 4,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic [CH_W-1:0]   ch_o,
  output logic [DATA_W-1:0] tap_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  import sar_adc_pkg::*;

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [DATA_W-1:0] MSB_ONE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  CNT_TOP = CNT_W'(SETTLE_CYC - 1);

  sar_state_e        state_q;
  logic [DATA_W-1:0] code_q, kept_code, next_trial, result_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CH_W-1:0]   ch_q;
  logic              done_q;

  always_comb begin
    kept_code        = code_q;
    kept_code[idx_q] = cmp_i;
  end

  always_comb begin
    next_trial = kept_code;
    next_trial[idx_q - IDX_W'(1)] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      code_q   <= '0;
      idx_q    <= '0;
      cnt_q    <= '0;
      ch_q     <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_STEP;
            code_q  <= MSB_ONE;
            idx_q   <= IDX_W'(DATA_W - 1);
            cnt_q   <= CNT_TOP;
            ch_q    <= ch_i;
          end
        end
        ST_STEP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
          end else if (idx_q == '0) begin
            code_q   <= kept_code;
            result_q <= kept_code;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            code_q <= next_trial;
            idx_q  <= idx_q - IDX_W'(1);
            cnt_q  <= CNT_TOP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == ST_STEP);
  assign ch_o     = ch_q;
  assign tap_o    = code_q;
  assign done_o   = done_q;
  assign result_o = result_q;

  // R7
  first_tap_msb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (tap_o == MSB_ONE));

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(ch_o));

  // R7
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: rtl/sar_adc_ctrl_regs.sv
module sar_adc_ctrl_regs #(
  parameter int CH_W   = 4,
  parameter int NUM_CH = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_i,
  input  logic [7:0]      wdata_i,
  input  logic            trig_fall_i,
  input  logic            busy_i,
  input  logic            done_i,
  output logic [7:0]      ctrl_o,
  output logic            start_o,
  output logic [CH_W-1:0] start_ch_o,
  output logic            ref_on_o,
  output logic            irq_o
);
  import sar_adc_pkg::*;

  localparam logic [CH_W-1:0] CH_MAX = CH_W'(NUM_CH - 1);

  logic [CH_W-1:0] ch_q;
  logic            done_flag_q, ref_sw_q, trig_en_q, irq_src_q;
  logic            ref_on_q, irq_q;
  logic            sw_start, hw_start;
  logic [CH_W-1:0] raw_ch;

  assign sw_start = wr_i & ~wdata_i[FLD_DONE] & ~trig_en_q & done_flag_q;
  assign hw_start = trig_fall_i & trig_en_q & done_flag_q;
  assign start_o  = sw_start | hw_start;

  assign raw_ch     = sw_start ? wdata_i[FLD_CH_LSB +: CH_W] : ch_q;
  assign start_ch_o = (raw_ch > CH_MAX) ? CH_MAX : raw_ch;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q        <= '0;
      done_flag_q <= 1'b1;
      ref_sw_q    <= 1'b0;
      trig_en_q   <= 1'b0;
      irq_src_q   <= 1'b0;
      ref_on_q    <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (wr_i) begin
        ch_q      <= wdata_i[FLD_CH_LSB +: CH_W];
        ref_sw_q  <= wdata_i[FLD_REFSW];
        trig_en_q <= wdata_i[FLD_TRIGEN];
        irq_src_q <= wdata_i[FLD_IRQSRC];
      end
      if (start_o)     done_flag_q <= 1'b0;
      else if (done_i) done_flag_q <= 1'b1;
      ref_on_q <= ref_sw_q | busy_i;
      irq_q    <= irq_src_q ? (trig_fall_i & trig_en_q) : done_i;
    end
  end

  always_comb begin
    ctrl_o                        = '0;
    ctrl_o[FLD_CH_LSB +: CH_W]    = ch_q;
    ctrl_o[FLD_DONE]              = done_flag_q;
    ctrl_o[FLD_REFSW]             = ref_sw_q;
    ctrl_o[FLD_TRIGEN]            = trig_en_q;
    ctrl_o[FLD_IRQSRC]            = irq_src_q;
  end

  assign ref_on_o = ref_on_q;
  assign irq_o    = irq_q;

  // R5
  trig_blocks_sw_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !wdata_i[FLD_DONE] && trig_en_q && done_flag_q && !trig_fall_i)
      |=> done_flag_q);

  // R9
  ref_follows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ref_on_o);

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  // R3
  start_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (done_flag_q && !busy_i));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int DATA_W      = 8,
  parameter int CH_W        = 4,
  parameter int NUM_CH      = 13,
  parameter int SETTLE_CYC  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_q,
  output logic [DATA_W-1:0] result_q,
  input  logic              trig_n,
  input  logic              cmp_in,
  output logic [CH_W-1:0]   ch_sel,
  output logic [DATA_W-1:0] tap_code,
  output logic              ref_on,
  output logic              irq
);
  import sar_adc_pkg::*;

  logic            trig_fall, start, busy, done;
  logic [CH_W-1:0] start_ch;

  sar_adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (trig_n),
    .fall_o (trig_fall)
  );

  sar_adc_ctrl_regs #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (reg_wr),
    .wdata_i     (reg_wdata),
    .trig_fall_i (trig_fall),
    .busy_i      (busy),
    .done_i      (done),
    .ctrl_o      (ctrl_q),
    .start_o     (start),
    .start_ch_o  (start_ch),
    .ref_on_o    (ref_on),
    .irq_o       (irq)
  );

  sar_adc_engine #(.DATA_W(DATA_W), .CH_W(CH_W), .SETTLE_CYC(SETTLE_CYC)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .ch_i     (start_ch),
    .cmp_i    (cmp_in),
    .busy_o   (busy),
    .ch_o     (ch_sel),
    .tap_o    (tap_code),
    .done_o   (done),
    .result_o (result_q)
  );

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[FLD_DONE] && !done) |-> $stable(result_q));
endmodule

// File: tb/sar_adc_ctrl_bench.sv
module sar_adc_ctrl_bench;
  localparam int SETTLE = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       trig_n = 1'b1;
  logic       cmp_in;
  logic [7:0] ctrl_q, result_q, tap_code;
  logic [3:0] ch_sel;
  logic       ref_on, irq;

  logic [7:0] vin [0:15];
  int checks = 0;
  int fails  = 0;
  int irq_cnt = 0;
  int irq_wide = 0;
  logic irq_prev = 1'b0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign cmp_in = (vin[ch_sel] >= tap_code);

  sar_adc_ctrl #(.SETTLE_CYC(SETTLE)) u_sar_adc_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .result_q(result_q), .trig_n(trig_n), .cmp_in(cmp_in),
    .ch_sel(ch_sel), .tap_code(tap_code), .ref_on(ref_on), .irq(irq)
  );

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (irq && irq_prev) irq_wide <= irq_wide + 1;
    irq_prev <= irq;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (ctrl_q[4] !== 1'b1 && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(n < 200), 1);
  endtask

  task automatic pulse_trig();
    @(negedge clk);
    trig_n = 1'b0;
    idle(4);
    trig_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_q, 8'h10);
    chk("R1 result", result_q, 0);
    chk("R1 ch_sel", ch_sel, 0);
    chk("R1 tap", tap_code, 0);
    chk("R1 ref_on", ref_on, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_sw_convert(input logic [3:0] ch, input logic [7:0] prev);
    irq_cnt = 0;
    wr({4'b0000, ch});
    chk("R3 flag low", ctrl_q[4], 0);
    chk("R7 first tap", tap_code, 8'h80);
    chk("R2 ch_sel", ch_sel, ch);
    idle(3);
    chk("R8 old result", result_q, prev);
    chk("R9 ref during conv", ref_on, 1);
    wait_done("R3 completes");
    chk("R7 result", result_q, vin[ch]);
    idle(2);
    chk("R9 ref released", ref_on, 0);
    chk("R10 irq count", irq_cnt, 1);
  endtask

  task automatic t_mid_write();
    wr(8'h03);
    idle(2);
    wr(8'h15);
    chk("R4 flag stays low", ctrl_q[4], 0);
    chk("R2 ch held", ch_sel, 3);
    wr(8'h05);
    chk("R4 busy write", ctrl_q, 8'h05);
    wait_done("R4 completes");
    chk("R2 result from old ch", result_q, vin[3]);
    chk("R4 ctrl after", ctrl_q, 8'h15);
    wr(8'h17);
    idle(6);
    chk("R4 write one no start", ctrl_q[4], 1);
    chk("R4 ch stored", ctrl_q[3:0], 7);
  endtask

  task automatic t_clamp();
    wr(8'h0E);
    chk("R2 clamp ch_sel", ch_sel, 12);
    wait_done("R2 clamp completes");
    chk("R2 clamp result", result_q, vin[12]);
  endtask

  task automatic t_trig_en();
    wr(8'h50);
    wr(8'h40);
    idle(4);
    chk("R5 no start", ctrl_q, 8'h50);
    irq_cnt = 0;
    pulse_trig();
    chk("R6 trig started", ctrl_q[4], 0);
    idle(4);
    pulse_trig();
    wait_done("R6 completes");
    chk("R6 result", result_q, vin[0]);
    idle(8 * SETTLE + 10);
    chk("R6 busy edge ignored", ctrl_q[4], 1);
    chk("R10 one irq", irq_cnt, 1);
  endtask

  task automatic t_irq_src();
    wr(8'hD1);
    idle(2);
    irq_cnt = 0;
    pulse_trig();
    idle(2);
    chk("R11 edge irq", irq_cnt, 1);
    wait_done("R11 completes");
    chk("R11 result ch1", result_q, vin[1]);
    idle(4);
    chk("R11 no done irq", irq_cnt, 1);
    wr(8'h91);
    irq_cnt = 0;
    pulse_trig();
    idle(4);
    chk("R11 disabled no irq", irq_cnt, 0);
    chk("R11 disabled no start", ctrl_q[4], 1);
  endtask

  task automatic t_ref_sw();
    wr(8'h30);
    idle(2);
    chk("R9 ref forced", ref_on, 1);
    wr(8'h10);
    idle(2);
    chk("R9 ref off", ref_on, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) vin[i] = 8'(i * 19 + 7);
    vin[0]  = 8'h00;
    vin[3]  = 8'hA5;
    vin[12] = 8'hFF;
    vin[5]  = 8'h3C;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_sw_convert(4'd3, 8'h00);
    t_sw_convert(4'd0, 8'hA5);
    t_sw_convert(4'd12, 8'h00);
    t_sw_convert(4'd5, 8'hFF);
    t_mid_write();
    t_clamp();
    t_ref_sw();
    t_trig_en();
    t_irq_src();
    chk("R10 irq single cycle", irq_wide, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule